// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer. Its write side and its read side each run on their own free-running clock. The two clocks may be unrelated, or they may be the same net. Each side has an active-low enable. Each enabled edge moves exactly one word in or out, unless the buffer is full (for writes) or empty (for reads).

Pointers cross between the clock domains as Gray code through two-stage synchronizers. Full and almost-full are registered in the write domain. Empty and almost-empty are registered in the read domain. Because the pointer seen from the other side lags, every flag errs on the safe side and is never optimistic.

The two threshold offsets are loaded from the write side. The read side uses a synchronized copy of its offset. The offsets are meant to be changed only while the buffer is quiet. The read data register drives the output bus only while the active-low output enable is low; otherwise the bus floats. Depth is a power-of-two parameter with a default of 256.

Top module: `dcf_fifo`

## Requirements
- R1: While wr_rst and rd_rst are high, and after they fall, the block shows empty=1, almost_empty=1, full=0 and almost_full=0. Both pointers are at zero and both offsets hold 7.
- R2: A word on wr_data is stored at a rising wr_clk edge where wr_en_n=0 and full=0. Holding wr_en_n low stores one word on every such edge.
- R3: A rising rd_clk edge with rd_en_n=0 and empty=0 loads the oldest unread word into the read data register. Words come out in the same order they were written, one per enabled edge.
- R4: full rises at the write edge that brings the stored count to DEPTH. empty rises at the read edge that takes the last word out.
- R5: almost_empty is 1 when the count seen by the read side is at or below the empty offset. almost_full is 1 when the free space seen by the write side is at or below the full offset.
- R6: A write attempted while full=1, or a read attempted while empty=1, has no effect. Neither pointer moves and no stored word changes.
- R7: The block works both with unrelated clocks and with rd_clk tied to wr_clk. After the first word is written into an empty buffer, empty falls within 4 rising rd_clk edges.
- R8: With out_en_n=1, rd_data is high impedance. With out_en_n=0, rd_data shows the read data register.
- R9: A rising wr_clk edge with cfg_ld=1 loads cfg_val into the empty offset when cfg_sel=0, or into the full offset when cfg_sel=1. The read side applies a new empty offset two rd_clk edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DW (18) | Word to store |
| cfg_ld | input | 1 | Load strobe for a threshold offset |
| cfg_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| cfg_val | input | AW+1 | Offset value to load |
| full | output | 1 | No free slot |
| almost_full | output | 1 | Free space at or below the full offset |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_n | input | 1 | Active-low read enable |
| out_en_n | input | 1 | Active-low output drive enable |
| rd_data | output | DW (18) | Read data register, or Z |
| empty | output | 1 | No unread word |
| almost_empty | output | 1 | Count at or below the empty offset |

## Verification
The bench fills the buffer to exactly DEPTH words and then keeps pushing. A design that lets the write pointer wrap there would overwrite the oldest word and break the drained sequence. It also pulls on an empty buffer; a design that moves the read pointer there would return a stale word ahead of the next real one. The threshold flags are probed one word either side of both the default and the reprogrammed offsets, which catches an off-by-one in either comparison. Streams run with unrelated clocks and again with tied clocks, and the time for empty to fall is measured, so a broken Gray conversion or a missing synchronizer stage shows up as wrong data or a late flag.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W  = 18;
  localparam int OFS_DEF = 7;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;
  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 8,
  localparam int NW = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NW];
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [PW-1:0] rgray_s,
  input  logic [PW-1:0] af_off,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          almost_full,
  output logic          we,
  output logic [AW-1:0] waddr
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          accept;
  logic [PW-1:0] rbin, bin_nxt, used_nxt, free_nxt;

  always_comb begin
    accept   = push && !full;
    rbin     = g2b(rgray_s);
    bin_nxt  = wbin + PW'(accept);
    used_nxt = bin_nxt - rbin;
    free_nxt = DEPTH_P - used_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= bin_nxt;
      wgray       <= bin_nxt ^ (bin_nxt >> 1);
      full        <= (used_nxt == DEPTH_P);
      almost_full <= (free_nxt <= af_off);
    end
  end

  assign we    = accept;
  assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_off,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          almost_empty,
  output logic          re,
  output logic [AW-1:0] raddr
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          accept;
  logic [PW-1:0] wbin, bin_nxt, cnt_nxt;

  always_comb begin
    accept  = pop && !empty;
    wbin    = g2b(wgray_s);
    bin_nxt = rbin + PW'(accept);
    cnt_nxt = wbin - bin_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= bin_nxt;
      rgray        <= bin_nxt ^ (bin_nxt >> 1);
      empty        <= (cnt_nxt == '0);
      almost_empty <= (cnt_nxt <= ae_off);
    end
  end

  assign re    = accept;
  assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = dcf_pkg::DATA_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_ld,
  input  logic          cfg_sel,
  input  logic [PW-1:0] cfg_val,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam logic [PW-1:0] OFS_RST = PW'(dcf_pkg::OFS_DEF);

  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_rd, rgray_wr;
  logic [PW-1:0] ae_off_w, af_off_w, ae_off_r;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rd_q;

  // Offset registers, write domain
  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      ae_off_w <= OFS_RST;
      af_off_w <= OFS_RST;
    end else if (cfg_ld) begin
      if (dcf_pkg::ofs_sel_e'(cfg_sel) == dcf_pkg::SEL_FULL) af_off_w <= cfg_val;
      else                                                   ae_off_w <= cfg_val;
    end
  end

  dcf_sync #(.W(PW), .RST_VAL(OFS_RST)) u_ofs_sync (
    .clk(rd_clk), .rst(rd_rst), .d(ae_off_w), .q(ae_off_r));

  dcf_sync #(.W(PW), .RST_VAL('0)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wptr_gray), .q(wgray_rd));

  dcf_sync #(.W(PW), .RST_VAL('0)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rptr_gray), .q(rgray_wr));

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .push(!wr_en_n), .rgray_s(rgray_wr),
    .af_off(af_off_w), .wbin(wptr_bin), .wgray(wptr_gray), .full(full),
    .almost_full(almost_full), .we(we), .waddr(waddr));

  dcf_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .pop(!rd_en_n), .wgray_s(wgray_rd),
    .ae_off(ae_off_r), .rbin(rptr_bin), .rgray(rptr_gray), .empty(empty),
    .almost_empty(almost_empty), .re(re), .raddr(raddr));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_q));

  assign rd_data = out_en_n ? {DW{1'bz}} : rd_q;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int PW = 9
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          full,
  input logic          empty,
  input logic          almost_full,
  input logic          almost_empty,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] wptr_gray
);
  // R6
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (full && !wr_en_n) |=> $stable(wptr_bin));
  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (empty && !rd_en_n) |=> $stable(rptr_bin));
  // R2
  wr_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (!full && !wr_en_n) |=> (wptr_bin == $past(wptr_bin) + 1'b1));
  // R7
  gray_onebit_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);
  // R5
  full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    full |-> almost_full);
  // R5
  empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |-> almost_empty);
endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .full(full), .empty(empty),
  .almost_full(almost_full), .almost_empty(almost_empty),
  .wptr_bin(wptr_bin), .rptr_bin(rptr_bin), .wptr_gray(wptr_gray));

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
  localparam int DEPTH = 16;
  localparam int DW    = 18;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic wr_clk = 0, rd_free = 0, tie = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_en_n = 1, rd_en_n = 1, out_en_n = 1;
  logic [DW-1:0] wr_data = '0;
  logic cfg_ld = 0, cfg_sel = 0;
  logic [PW-1:0] cfg_val = '0;
  logic full, almost_full, empty, almost_empty;
  logic [DW-1:0] rd_data;
  logic rd_clk;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_free = ~rd_free;
  assign rd_clk = tie ? wr_clk : rd_free;

  dcf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .cfg_ld(cfg_ld), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .full(full), .almost_full(almost_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en_n(rd_en_n), .out_en_n(out_en_n),
    .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty));

  int nchk = 0, nfail = 0, nread = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd;
  bit rd_on = 0, pend = 0, done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard for every accepted read (R3)
  always @(negedge rd_clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected word", 32'(rd_data), 32'h0);
      else begin
        last_rd = exp_q.pop_front();
        chk(rd_data === last_rd, "R3 order", 32'(rd_data), 32'(last_rd));
        nread++;
      end
      pend = 0;
    end
    if (rd_on) begin
      if (!empty) begin rd_en_n = 0; pend = 1; end
      else rd_en_n = 1;
    end
  end

  // Driver: one write attempt, pushes expected item if accepted (R2)
  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_data = d;
    wr_en_n = 0;
    if (!full) exp_q.push_back(d);
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic wr_burst(input int n, input int seed);
    @(negedge wr_clk);
    for (int i = 0; i < n; i++) begin
      wr_data = DW'(seed * 131 + i * 37 + 5);
      wr_en_n = 0;
      if (!full) exp_q.push_back(wr_data);
      @(negedge wr_clk);
    end
    wr_en_n = 1;
  endtask

  task automatic rd_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  task automatic drain(input string req);
    int lim = 0;
    rd_on = 1;
    while ((exp_q.size() != 0 || pend) && lim < 2000) begin
      @(negedge rd_clk); lim++;
    end
    rd_wait(2);
    rd_on = 0;
    rd_en_n = 1;
    rd_wait(8);
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
  endtask

  task automatic do_reset();
    wr_rst = 1; rd_rst = 1; rd_on = 0; rd_en_n = 1; wr_en_n = 1;
    exp_q.delete();
    repeat (6) @(negedge wr_clk);
    rd_wait(4);
    chk(empty && almost_empty && !full && !almost_full, "R1 flags in reset",
        {28'h0, empty, almost_empty, full, almost_full}, 32'hC);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    rd_wait(2);
    chk(empty && almost_empty && !full && !almost_full, "R1 flags after reset",
        {28'h0, empty, almost_empty, full, almost_full}, 32'hC);
  endtask

  task automatic load_ofs(input logic sel, input logic [PW-1:0] v);
    @(negedge wr_clk);
    cfg_ld = 1; cfg_sel = sel; cfg_val = v;
    @(negedge wr_clk);
    cfg_ld = 0;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int edges, pushed;
    do_reset();
    // R8: output floats while disabled
    chk(rd_data === {DW{1'bz}}, "R8 bus floats", 32'(rd_data), 32'h0);
    out_en_n = 0;

    // R7: empty falls within 4 read edges after the first write
    wr_word(18'h2A5A5);
    edges = 0;
    while (empty && edges < 10) begin @(posedge rd_clk); edges++; #1; end
    chk(edges <= 4, "R7 empty latency", 32'(edges), 32'h4);
    drain("R3 single word");

    // R2 R3: streaming with reads running
    rd_on = 1;
    wr_burst(60, 1);
    drain("R2 stream drained");

    // R4: fill to full, then R6 overflow attempts
    nread = 0;
    pushed = exp_q.size();
    wr_burst(DEPTH, 2);
    chk(exp_q.size() == DEPTH, "R2 all accepted", 32'(exp_q.size()), 32'(DEPTH));
    chk(full === 1'b1, "R4 full at DEPTH", 32'(full), 32'h1);
    chk(almost_full === 1'b1, "R5 af when full", 32'(almost_full), 32'h1);
    @(negedge wr_clk);
    wr_data = 18'h3FFFF; wr_en_n = 0;
    repeat (3) @(negedge wr_clk);
    wr_en_n = 1;
    chk(full === 1'b1, "R6 still full", 32'(full), 32'h1);
    drain("R6 overflow no corruption");
    chk(nread == DEPTH, "R6 overflow count", 32'(nread), 32'(DEPTH));
    chk(empty === 1'b1, "R4 empty after drain", 32'(empty), 32'h1);

    // R5: default offsets (7)
    wr_burst(7, 3);
    rd_wait(8);
    chk(almost_empty === 1'b1, "R5 ae at 7", 32'(almost_empty), 32'h1);
    wr_burst(1, 4);
    rd_wait(8);
    chk(almost_empty === 1'b0, "R5 ae at 8", 32'(almost_empty), 32'h0);
    chk(almost_full === 1'b0, "R5 af free 8", 32'(almost_full), 32'h0);
    wr_burst(1, 5);
    chk(almost_full === 1'b1, "R5 af free 7", 32'(almost_full), 32'h1);
    drain("R5 drain");

    // R9: new offsets, empty 2 and full 3
    load_ofs(1'b0, PW'(2));
    load_ofs(1'b1, PW'(3));
    rd_wait(4);
    wr_burst(2, 6);
    rd_wait(8);
    chk(almost_empty === 1'b1, "R9 ae at 2", 32'(almost_empty), 32'h1);
    wr_burst(1, 7);
    rd_wait(8);
    chk(almost_empty === 1'b0, "R9 ae at 3", 32'(almost_empty), 32'h0);
    wr_burst(9, 8);
    chk(almost_full === 1'b0, "R9 af free 4", 32'(almost_full), 32'h0);
    wr_burst(1, 9);
    chk(almost_full === 1'b1, "R9 af free 3", 32'(almost_full), 32'h1);
    drain("R9 drain");

    // R6: reads on an empty buffer are ignored
    @(negedge rd_clk); rd_en_n = 0;
    rd_wait(4);
    rd_en_n = 1;
    chk(empty === 1'b1, "R6 empty stays", 32'(empty), 32'h1);
    wr_word(18'h1B2C3);
    drain("R6 underflow no skip");

    // R8: enable toggles the bus over held data
    out_en_n = 1;
    rd_wait(1);
    chk(rd_data === {DW{1'bz}}, "R8 float with data", 32'(rd_data), 32'h0);
    out_en_n = 0;
    rd_wait(1);
    chk(rd_data === 18'h1B2C3, "R8 drive held word", 32'(rd_data), 32'h1B2C3);

    // R7: tied clocks
    tie = 1;
    do_reset();
    rd_on = 1;
    wr_burst(40, 10);
    drain("R7 tied stream");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule